// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block is a small scheduling buffer that sits in front of one functional unit in an out-of-order core. The rename stage dispatches instructions into it even when their operands are still being computed elsewhere. For each source, the instruction carries a tag naming the producer and, if the value already exists, the value itself. The station records the tags of missing operands and watches a shared result bus. That bus carries one tag and one value per cycle.

Every occupied entry compares both of its waiting source tags against each broadcast. On a match, the entry latches the bus value and marks that source present. Once both sources of an entry are present, the entry competes for the functional unit. If several entries compete, the one dispatched earliest wins, wherever it sits in the buffer. Because wake-up is driven only by the bus, a producer of any latency can feed the station without any timing contract.

Top module: `tag_rs_station`

## Requirements
- R1: Out of reset, the station is empty: `disp_ready` is 1 and `iss_valid` is 0.
- R2: An instruction dispatched with both sources marked ready (`*_rdy`=1) is offered on the issue port in the cycle after the dispatch edge. It carries the two dispatched values and its sink tag.
- R3: A source dispatched with its ready flag at 0 holds the entry back until a broadcast with `bus_valid`=1 and a tag equal to that source's tag. The operand value then issued is the broadcast `bus_val`, and the entry can issue in the cycle after that broadcast edge.
- R4: A broadcast whose tag differs from every waiting source tag, or any bus cycle with `bus_valid`=0, has no effect on any entry.
- R5: If a waiting source tag matches a valid broadcast in the same cycle as its dispatch, the bus value is captured at that dispatch edge.
- R6: A single broadcast wakes every waiting source that carries its tag: both sources of one entry and sources in several entries.
- R7: Entries leave in operand-ready order. A later-dispatched entry whose operands complete first is issued before an earlier entry that is still waiting.
- R8: When several entries are ready at once, the one dispatched earliest is issued first, independent of its slot position.
- R9: With all ENTRIES (4) slots occupied, `disp_ready` is 0 and a dispatch attempt is ignored.
- R10: While `iss_valid`=1 and `iss_ready`=0, `iss_valid` stays 1. An issued entry is freed by the handshake edge, so `disp_ready` returns to 1 after one issue from a full station.
- R11: A source that is already ready keeps its value; later broadcasts that match its tag do not overwrite it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A free entry exists |
| disp_a_rdy | input | 1 | Source A value present |
| disp_a_tag | input | 4 | Source A producer tag |
| disp_a_val | input | 16 | Source A value (used when present) |
| disp_b_rdy | input | 1 | Source B value present |
| disp_b_tag | input | 4 | Source B producer tag |
| disp_b_val | input | 16 | Source B value (used when present) |
| disp_sink | input | 4 | Tag of the result this instruction produces |
| bus_valid | input | 1 | Result bus carries a broadcast |
| bus_tag | input | 4 | Broadcast tag |
| bus_val | input | 16 | Broadcast value |
| iss_valid | output | 1 | An entry is offered to the unit |
| iss_ready | input | 1 | Unit accepts the offered entry |
| iss_op_a | output | 16 | Operand A of the offered entry |
| iss_op_b | output | 16 | Operand B of the offered entry |
| iss_sink | output | 4 | Sink tag of the offered entry |

## Verification
The hardest case to reach is an age order that differs from slot order while several entries become ready on the same broadcast. The bench fills all slots and wakes and drains two of them out of order. It then refills the freed low slots with younger instructions, so one tag wakes four entries whose dispatch order is not their index order. Out-of-order departure is swept over all 24 wake orders of a full station. Tag discrimination is swept over every pair of waiting tag and broadcast tag.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int TAG_W  = 4;
  parameter int DATA_W = 16;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef struct packed {
    logic  rdy;
    tag_t  tag;
    data_t val;
  } src_t;

  typedef struct packed {
    src_t a;
    src_t b;
    tag_t sink;
  } uop_t;

  // a waiting source that the current broadcast completes
  function automatic logic snoop_hit(src_t s, logic bv, tag_t bt);
    return bv && !s.rdy && (s.tag == bt);
  endfunction

  // source after observing one bus cycle
  function automatic src_t snoop(src_t s, logic bv, tag_t bt, data_t bd);
    src_t r;
    r = s;
    if (snoop_hit(s, bv, bt)) begin
      r.rdy = 1'b1;
      r.val = bd;
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  uop_t  load_uop,
  input  logic  clear,
  input  logic  bus_valid,
  input  tag_t  bus_tag,
  input  data_t bus_val,
  output logic  valid,
  output logic  ready,
  output uop_t  uop
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      uop   <= '0;
    end else if (load) begin
      valid    <= 1'b1;
      uop.a    <= snoop(load_uop.a, bus_valid, bus_tag, bus_val);
      uop.b    <= snoop(load_uop.b, bus_valid, bus_tag, bus_val);
      uop.sink <= load_uop.sink;
    end else begin
      if (clear) valid <= 1'b0;
      if (valid) begin
        uop.a <= snoop(uop.a, bus_valid, bus_tag, bus_val);
        uop.b <= snoop(uop.b, bus_valid, bus_tag, bus_val);
      end
    end
  end

  assign ready = valid && uop.a.rdy && uop.b.rdy;
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc,
  input  logic [N-1:0] valid,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // older_q[i][j] = 1 when slot i was dispatched before slot j
  logic [N-1:0][N-1:0] older_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (alloc[i])      older_q[i][j] <= 1'b0;
          else if (alloc[j]) older_q[i][j] <= valid[i] && (i != j);
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_pick
    logic [N-1:0] beaten;
    for (genvar k = 0; k < N; k++) begin : g_cmp
      assign beaten[k] = req[k] && older_q[k][g];
    end
    assign grant[g] = req[g] && !(|beaten);
  end
endmodule

// File: rtl/tag_rs_station.sv
module tag_rs_station #(
  parameter int ENTRIES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  output logic                     disp_ready,
  input  logic                     disp_a_rdy,
  input  logic [rs_pkg::TAG_W-1:0]  disp_a_tag,
  input  logic [rs_pkg::DATA_W-1:0] disp_a_val,
  input  logic                     disp_b_rdy,
  input  logic [rs_pkg::TAG_W-1:0]  disp_b_tag,
  input  logic [rs_pkg::DATA_W-1:0] disp_b_val,
  input  logic [rs_pkg::TAG_W-1:0]  disp_sink,
  input  logic                     bus_valid,
  input  logic [rs_pkg::TAG_W-1:0]  bus_tag,
  input  logic [rs_pkg::DATA_W-1:0] bus_val,
  output logic                     iss_valid,
  input  logic                     iss_ready,
  output logic [rs_pkg::DATA_W-1:0] iss_op_a,
  output logic [rs_pkg::DATA_W-1:0] iss_op_b,
  output logic [rs_pkg::TAG_W-1:0]  iss_sink
);
  import rs_pkg::*;

  logic [ENTRIES-1:0] ent_valid, ent_ready, free_sel, alloc_oh, grant, clr;
  uop_t               ent_uop [ENTRIES];
  uop_t               disp_uop, pick;
  logic               disp_fire, iss_fire;

  always_comb begin
    disp_uop.a.rdy = disp_a_rdy;
    disp_uop.a.tag = disp_a_tag;
    disp_uop.a.val = disp_a_val;
    disp_uop.b.rdy = disp_b_rdy;
    disp_uop.b.tag = disp_b_tag;
    disp_uop.b.val = disp_b_val;
    disp_uop.sink  = disp_sink;
  end

  // lowest free slot
  always_comb begin
    free_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_sel    = '0;
        free_sel[i] = 1'b1;
      end
    end
  end

  assign disp_ready = !(&ent_valid);
  assign disp_fire  = disp_valid && disp_ready;
  assign alloc_oh   = disp_fire ? free_sel : '0;

  for (genvar s = 0; s < ENTRIES; s++) begin : g_slot
    rs_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (alloc_oh[s]),
      .load_uop  (disp_uop),
      .clear     (clr[s]),
      .bus_valid (bus_valid),
      .bus_tag   (bus_tag),
      .bus_val   (bus_val),
      .valid     (ent_valid[s]),
      .ready     (ent_ready[s]),
      .uop       (ent_uop[s])
    );
  end

  rs_age_pick #(.N(ENTRIES)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .alloc (alloc_oh),
    .valid (ent_valid),
    .req   (ent_ready),
    .grant (grant)
  );

  assign iss_valid = |grant;
  assign iss_fire  = iss_valid && iss_ready;
  assign clr       = iss_fire ? grant : '0;

  always_comb begin
    pick = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant[i]) pick = uop_t'(pick | ent_uop[i]);
    end
  end

  assign iss_op_a = pick.a.val;
  assign iss_op_b = pick.b.val;
  assign iss_sink = pick.sink;
endmodule

// File: rtl/rs_sva.sv
module rs_sva #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         disp_ready,
  input logic         bus_valid,
  input logic         iss_valid,
  input logic         iss_ready,
  input logic [N-1:0] ent_valid,
  input logic [N-1:0] ent_ready,
  input logic [N-1:0] grant,
  input logic         disp_fire,
  input logic         iss_fire
);
  p_single_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_in_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> ((grant & ent_valid) == grant));

  p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&ent_valid) |-> !disp_ready);

  p_occupancy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(ent_valid) ==
              $past($countones(ent_valid)) + int'($past(disp_fire)) - int'($past(iss_fire))));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> iss_valid);

  p_wake_needs_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && !disp_fire) |=> ($countones(ent_ready) <= $past($countones(ent_ready))));
endmodule

bind tag_rs_station rs_sva #(.N(ENTRIES)) u_rs_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_ready (disp_ready),
  .bus_valid  (bus_valid),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .ent_valid  (ent_valid),
  .ent_ready  (ent_ready),
  .grant      (grant),
  .disp_fire  (disp_fire),
  .iss_fire   (iss_fire)
);

// File: tb/test_tag_rs_station.sv
`timescale 1ns/1ps
module test_tag_rs_station;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0, disp_ready;
  logic        disp_a_rdy = 1'b0, disp_b_rdy = 1'b0;
  logic [3:0]  disp_a_tag = '0, disp_b_tag = '0, disp_sink = '0;
  logic [15:0] disp_a_val = '0, disp_b_val = '0;
  logic        bus_valid = 1'b0;
  logic [3:0]  bus_tag = '0;
  logic [15:0] bus_val = '0;
  logic        iss_valid, iss_ready = 1'b0;
  logic [15:0] iss_op_a, iss_op_b;
  logic [3:0]  iss_sink;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tag_rs_station i_tag_rs_station (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_a_rdy(disp_a_rdy), .disp_a_tag(disp_a_tag), .disp_a_val(disp_a_val),
    .disp_b_rdy(disp_b_rdy), .disp_b_tag(disp_b_tag), .disp_b_val(disp_b_val),
    .disp_sink(disp_sink),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op_a(iss_op_a), .iss_op_b(iss_op_b), .iss_sink(iss_sink)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic see(input string req, input logic [3:0] sink,
                     input logic [15:0] a, input logic [15:0] b);
    chk({req, " valid"}, 32'(iss_valid), 32'd1);
    chk({req, " sink"},  32'(iss_sink),  32'(sink));
    chk({req, " op_a"},  32'(iss_op_a),  32'(a));
    chk({req, " op_b"},  32'(iss_op_b),  32'(b));
  endtask

  // drive a dispatch for one edge, optionally with a broadcast in the same cycle
  task automatic disp(input logic ar, input logic [3:0] at, input logic [15:0] av,
                      input logic br, input logic [3:0] bt, input logic [15:0] bv,
                      input logic [3:0] sink);
    disp_valid = 1'b1;
    disp_a_rdy = ar; disp_a_tag = at; disp_a_val = av;
    disp_b_rdy = br; disp_b_tag = bt; disp_b_val = bv;
    disp_sink  = sink;
    step();
    disp_valid = 1'b0;
  endtask

  task automatic bcast(input logic v, input logic [3:0] t, input logic [15:0] d);
    bus_valid = v; bus_tag = t; bus_val = d;
    step();
    bus_valid = 1'b0;
  endtask

  task automatic drain_one();
    iss_ready = 1'b1;
    step();
    iss_ready = 1'b0;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1 disp_ready", 32'(disp_ready), 32'd1);
    chk("R1 iss_valid",  32'(iss_valid),  32'd0);
    rst_n = 1'b1;
    step();

    // R2 both sources present at dispatch
    disp(1'b1, 4'd0, 16'h1234, 1'b1, 4'd0, 16'h0042, 4'd3);
    see("R2", 4'd3, 16'h1234, 16'h0042);
    drain_one();
    chk("R2 drained", 32'(iss_valid), 32'd0);

    // R3/R4 sweep: waiting tag vs every other broadcast tag
    for (int t = 0; t < 16; t++) begin
      disp(1'b0, 4'(t), 16'h0, 1'b1, 4'(15 - t), 16'(t * 3), 4'(t));
      for (int u = 0; u < 16; u++) begin
        if (u != t) begin
          bcast(1'b1, 4'(u), 16'hFFFF);
          chk("R4 mismatched tag", 32'(iss_valid), 32'd0);
        end
      end
      bcast(1'b0, 4'(t), 16'hEEEE);
      chk("R4 bus idle", 32'(iss_valid), 32'd0);
      bcast(1'b1, 4'(t), 16'(t * 257 + 1));
      see("R3", 4'(t), 16'(t * 257 + 1), 16'(t * 3));
      drain_one();
    end

    // R5 capture on the dispatch edge, either source
    for (int s = 0; s < 2; s++) begin
      bus_valid = 1'b1; bus_tag = 4'd5; bus_val = 16'(16'h0A0A + s);
      if (s == 0) disp(1'b0, 4'd5, 16'h0, 1'b1, 4'd1, 16'h0101, 4'd7);
      else        disp(1'b1, 4'd1, 16'h0101, 1'b0, 4'd5, 16'h0, 4'd7);
      bus_valid = 1'b0;
      if (s == 0) see("R5 src a", 4'd7, 16'h0A0A, 16'h0101);
      else        see("R5 src b", 4'd7, 16'h0101, 16'h0A0B);
      drain_one();
    end

    // R6 one broadcast wakes two sources of one entry and a second entry
    disp(1'b0, 4'd7, 16'h0, 1'b0, 4'd7, 16'h0, 4'd1);
    disp(1'b1, 4'd2, 16'h0033, 1'b0, 4'd7, 16'h0, 4'd2);
    bcast(1'b1, 4'd7, 16'h0077);
    see("R6 first", 4'd1, 16'h0077, 16'h0077);
    iss_ready = 1'b1;
    step();
    see("R6 second", 4'd2, 16'h0033, 16'h0077);
    step();
    iss_ready = 1'b0;
    chk("R6 empty", 32'(iss_valid), 32'd0);

    // R11 ready source ignores a matching broadcast
    disp(1'b1, 4'd4, 16'h1111, 1'b0, 4'd6, 16'h0, 4'd9);
    bcast(1'b1, 4'd4, 16'hDEAD);
    chk("R11 still waiting", 32'(iss_valid), 32'd0);
    bcast(1'b1, 4'd6, 16'h0606);
    see("R11", 4'd9, 16'h1111, 16'h0606);
    drain_one();

    // R7/R9 all wake orders of a full station
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              int ord [4];
              ord[0] = a; ord[1] = b; ord[2] = c; ord[3] = d;
              for (int k = 0; k < 4; k++)
                disp(1'b0, 4'(8 + k), 16'h0, 1'b1, 4'd0, 16'(k), 4'(k + 1));
              chk("R9 full", 32'(disp_ready), 32'd0);
              disp(1'b1, 4'd0, 16'hBAD0, 1'b1, 4'd0, 16'hBAD1, 4'd15);
              iss_ready = 1'b1;
              for (int k = 0; k < 4; k++) begin
                bcast(1'b1, 4'(8 + ord[k]), 16'(100 * ord[k] + k));
                see("R7 order", 4'(ord[k] + 1), 16'(100 * ord[k] + k), 16'(ord[k]));
                step();
                chk("R7 departed", 32'(iss_valid), 32'd0);
              end
              iss_ready = 1'b0;
              chk("R9 refused dispatch", 32'(iss_valid), 32'd0);
            end
          end

    // R8 oldest-first when age differs from slot order
    iss_ready = 1'b1;
    disp(1'b0, 4'd9, 16'h0, 1'b1, 4'd0, 16'h00A0, 4'd10);
    disp(1'b0, 4'd2, 16'h0, 1'b1, 4'd0, 16'h00B0, 4'd11);
    disp(1'b0, 4'd9, 16'h0, 1'b1, 4'd0, 16'h00C0, 4'd12);
    disp(1'b0, 4'd3, 16'h0, 1'b1, 4'd0, 16'h00D0, 4'd13);
    bcast(1'b1, 4'd2, 16'h0002);
    see("R8 prep b", 4'd11, 16'h0002, 16'h00B0);
    step();
    bcast(1'b1, 4'd3, 16'h0003);
    see("R8 prep d", 4'd13, 16'h0003, 16'h00D0);
    step();
    disp(1'b0, 4'd9, 16'h0, 1'b1, 4'd0, 16'h00E0, 4'd14);
    disp(1'b0, 4'd9, 16'h0, 1'b1, 4'd0, 16'h00F0, 4'd15);
    bcast(1'b1, 4'd9, 16'h0099);
    see("R8 1st", 4'd10, 16'h0099, 16'h00A0);
    step();
    see("R8 2nd", 4'd12, 16'h0099, 16'h00C0);
    step();
    see("R8 3rd", 4'd14, 16'h0099, 16'h00E0);
    step();
    see("R8 4th", 4'd15, 16'h0099, 16'h00F0);
    step();
    chk("R8 empty", 32'(iss_valid), 32'd0);
    iss_ready = 1'b0;

    // R10 stall holds the offer; a handshake frees a slot
    disp(1'b1, 4'd0, 16'h0606, 1'b1, 4'd0, 16'h0707, 4'd6);
    for (int k = 0; k < 3; k++) begin
      step();
      see("R10 stalled", 4'd6, 16'h0606, 16'h0707);
    end
    for (int k = 0; k < 3; k++)
      disp(1'b1, 4'd0, 16'(k), 1'b1, 4'd0, 16'(k), 4'(k));
    chk("R10 full", 32'(disp_ready), 32'd0);
    see("R10 oldest offered", 4'd6, 16'h0606, 16'h0707);
    drain_one();
    chk("R10 slot freed", 32'(disp_ready), 32'd1);
    see("R10 next", 4'd0, 16'd0, 16'd0);
    iss_ready = 1'b1;
    repeat (3) step();
    iss_ready = 1'b0;
    chk("R10 drained", 32'(iss_valid), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule